// File: doc/BRIEF.md
# Periodic Interrupt Generator for a Real-Time Clock

This block produces the periodic interrupt of a real-time clock on an active-low, open-drain style pin. A prescaled time base delivers `tick` strobes at `TICKS_PER_SEC` per second. The block counts these ticks into seconds and marks each second boundary on `sec_strobe`, which is the increment point of the seconds counter. A 3-bit select picks the interrupt period and its output mode.

In the two pulse modes the pin carries a square wave at 1 Hz or 2 Hz. Its low phase starts at the second boundary. In the two level modes a periodic flag is set on every second or on every minute boundary. The pin stays low until software writes 0 to the flag through `flag_wr` and `flag_wdata`.

A signed oscillation-adjust step is sampled once in each window of `WINDOW_SEC` seconds. The second that opens the window is then lengthened or shortened by that many ticks, clamped to `MAX_ADJ`. The change always falls inside the low phase of the pulse output.

Top module: `rtc_periodic_irq`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, with `period_sel` = 0, `irq_n` is 1, `flag` is 0 and `sec_strobe` is 0.
- R2: The block keeps a tick position from 0 to TICKS_PER_SEC-1 that starts at 0 after reset. A tick taken at the last position, with no adjustment hold pending, is a second boundary. `sec_strobe` is high for exactly the one clock cycle after the edge that takes that tick.
- R3: With `period_sel` = 3'b010 (1 Hz pulse), `irq_n` is 0 while the position is below TICKS_PER_SEC/2 or an adjustment hold is pending, and 1 otherwise. This gives a 50 % duty cycle in an unadjusted second.
- R4: With `period_sel` = 3'b001 (2 Hz pulse), `irq_n` is 0 while the position modulo TICKS_PER_SEC/2 is below TICKS_PER_SEC/4, and 1 otherwise.
- R5: With `period_sel` = 3'b011 (level, 1 s), every second boundary sets `flag` in the same cycle that `sec_strobe` goes high, and `irq_n` equals the inverse of `flag`.
- R6: With `period_sel` = 3'b100 (level, 1 min), `flag` is set only on the boundary that completes every 60th second counted since reset, and `irq_n` equals the inverse of `flag`.
- R7: A cycle with `flag_wr` = 1 and `flag_wdata` = 0 clears `flag`. With `flag_wdata` = 1 the write leaves `flag` unchanged. When a set and a clearing write fall in the same cycle, the set wins.
- R8: With `period_sel` = 0 or 3'b101 to 3'b111, `irq_n` stays 1 and no boundary sets `flag`.
- R9: Windows of WINDOW_SEC seconds are counted from reset. On the boundary that starts a new window, `adj_step` (two's complement) is clamped to ±MAX_ADJ. A positive value n holds the position at 0 for n extra ticks. A negative value -n starts the new second at position n. Other seconds keep TICKS_PER_SEC ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time-base strobe |
| period_sel | input | 3 | Period and mode select |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| adj_step | input | ADJ_W | Signed oscillation-adjust step in ticks |
| sec_strobe | output | 1 | Second-boundary pulse |
| flag | output | 1 | Periodic flag readback |
| irq_n | output | 1 | Interrupt pin, 0 = pulled low, 1 = released |

## Verification
A wrong tick position shows on `irq_n` in a pulse mode within a few ticks, because the pin edges move against the second strobes. A wrong hold or skip count stays hidden until the first second of a window. That can take up to WINDOW_SEC seconds, and it then shows as a longer or shorter low phase. A wrong minute count shows only when the minute flag rises, so a full 60 second run in the 1 min level mode is needed. A flag that mishandles writes shows on the next `flag` sample after the write.

// File: rtl/rpi_pkg.sv
package rpi_pkg;

  typedef enum logic [2:0] {
    RPI_OFF       = 3'd0,
    RPI_PULSE_2HZ = 3'd1,
    RPI_PULSE_1HZ = 3'd2,
    RPI_LEVEL_SEC = 3'd3,
    RPI_LEVEL_MIN = 3'd4
  } rpi_mode_e;

  typedef struct packed {
    logic pulse_fast;
    logic pulse_slow;
    logic level_sec;
    logic level_min;
  } rpi_dec_t;

  function automatic rpi_dec_t rpi_decode(input logic [2:0] sel);
    rpi_dec_t d;
    d = '0;
    case (sel)
      RPI_PULSE_2HZ: d.pulse_fast = 1'b1;
      RPI_PULSE_1HZ: d.pulse_slow = 1'b1;
      RPI_LEVEL_SEC: d.level_sec  = 1'b1;
      RPI_LEVEL_MIN: d.level_min  = 1'b1;
      default:       d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rpi_timebase.sv
module rpi_timebase #(
  parameter int TICKS_PER_SEC = 32,
  parameter int WINDOW_SEC    = 20,
  parameter int MAX_ADJ       = 3,
  parameter int ADJ_W         = 4,
  localparam int POS_W   = $clog2(TICKS_PER_SEC),
  localparam int STALL_W = (MAX_ADJ < 1) ? 1 : $clog2(MAX_ADJ + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic signed [ADJ_W-1:0] adj_step,
  output logic [POS_W-1:0]        pos_o,
  output logic                    stall_o,
  output logic                    boundary_o,
  output logic                    sec_strobe_o
);

  localparam int WIN_W = (WINDOW_SEC > 1) ? $clog2(WINDOW_SEC) : 1;

  logic [POS_W-1:0]   pos_q;
  logic [STALL_W-1:0] stall_q;
  logic [WIN_W-1:0]   win_q;
  logic               str_q;
  logic               bnd;
  logic               win_wrap;
  int                 a_clip;
  logic               adj_neg;
  logic [STALL_W-1:0] adj_mag;

  assign bnd      = tick && (stall_q == '0) && (pos_q == POS_W'(TICKS_PER_SEC - 1));
  assign win_wrap = (win_q == WIN_W'(WINDOW_SEC - 1));

  // clamp the signed step to the permitted correction
  always_comb begin
    a_clip = int'(adj_step);
    if (a_clip > MAX_ADJ)       a_clip = MAX_ADJ;
    else if (a_clip < -MAX_ADJ) a_clip = -MAX_ADJ;
    adj_neg = (a_clip < 0);
    adj_mag = adj_neg ? STALL_W'(-a_clip) : STALL_W'(a_clip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      stall_q <= '0;
      win_q   <= '0;
      str_q   <= 1'b0;
    end else begin
      str_q <= bnd;
      if (tick) begin
        if (stall_q != '0) begin
          stall_q <= stall_q - 1'b1;
        end else if (bnd) begin
          win_q <= win_wrap ? '0 : win_q + 1'b1;
          if (win_wrap) begin
            if (adj_neg) begin
              pos_q <= POS_W'(adj_mag);
            end else begin
              pos_q   <= '0;
              stall_q <= adj_mag;
            end
          end else begin
            pos_q <= '0;
          end
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign pos_o        = pos_q;
  assign stall_o      = (stall_q != '0);
  assign boundary_o   = bnd;
  assign sec_strobe_o = str_q;

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    str_q |=> !str_q);
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(TICKS_PER_SEC - 1));
  p_stall_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stall_q) <= MAX_ADJ);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q != '0) |-> (pos_q == '0));

endmodule

// File: rtl/rpi_wave.sv
module rpi_wave
  import rpi_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32,
  localparam int POS_W = $clog2(TICKS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  input  logic             stall,
  input  rpi_dec_t         dec,
  output logic             pulse_low
);

  localparam int HALF = TICKS_PER_SEC / 2;
  localparam int QTR  = TICKS_PER_SEC / 4;
  localparam bit POW2 = ((TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0) && (TICKS_PER_SEC >= 4);

  logic slow_low;
  logic fast_low;

  generate
    if (POW2) begin : g_bits
      assign slow_low = ~pos[POS_W-1];
      assign fast_low = ~pos[POS_W-2];
    end else begin : g_cmp
      assign slow_low = (pos < POS_W'(HALF));
      assign fast_low = (pos < POS_W'(QTR)) ||
                        ((pos >= POS_W'(HALF)) && (pos < POS_W'(HALF + QTR)));
    end
  endgenerate

  always_comb begin
    if (stall) pulse_low = dec.pulse_fast | dec.pulse_slow;
    else       pulse_low = (dec.pulse_fast & fast_low) | (dec.pulse_slow & slow_low);
  end

  p_stall_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && dec.pulse_slow) |-> pulse_low);
  p_no_pulse_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec.pulse_fast | dec.pulse_slow) |-> !pulse_low);

endmodule

// File: rtl/rpi_flag.sv
module rpi_flag #(
  parameter int SEC_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic level_sec,
  input  logic level_min,
  input  logic wr,
  input  logic wdata,
  output logic flag
);

  localparam int MIN_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  logic [MIN_W-1:0] min_q;
  logic             min_wrap;
  logic             set_evt;
  logic             clr_evt;
  logic             flag_q;

  assign min_wrap = (min_q == MIN_W'(SEC_PER_MIN - 1));
  assign set_evt  = boundary && (level_sec || (level_min && min_wrap));
  assign clr_evt  = wr && !wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (boundary) min_q <= min_wrap ? '0 : min_q + 1'b1;
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata && !set_evt) |=> !flag_q);
  p_one_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata && !set_evt) |=> (flag_q == $past(flag_q)));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  p_min_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    min_q <= MIN_W'(SEC_PER_MIN - 1));

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rpi_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32,
  parameter int WINDOW_SEC    = 20,
  parameter int SEC_PER_MIN   = 60,
  parameter int MAX_ADJ       = 3,
  parameter int ADJ_W         = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [2:0]              period_sel,
  input  logic                    flag_wr,
  input  logic                    flag_wdata,
  input  logic signed [ADJ_W-1:0] adj_step,
  output logic                    sec_strobe,
  output logic                    flag,
  output logic                    irq_n
);

  localparam int POS_W = $clog2(TICKS_PER_SEC);

  rpi_dec_t         dec;
  logic [POS_W-1:0] pos;
  logic             stall;
  logic             boundary;
  logic             pulse_low;

  assign dec = rpi_decode(period_sel);

  rpi_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .WINDOW_SEC   (WINDOW_SEC),
    .MAX_ADJ      (MAX_ADJ),
    .ADJ_W        (ADJ_W)
  ) u_tb (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .adj_step    (adj_step),
    .pos_o       (pos),
    .stall_o     (stall),
    .boundary_o  (boundary),
    .sec_strobe_o(sec_strobe)
  );

  rpi_wave #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos      (pos),
    .stall    (stall),
    .dec      (dec),
    .pulse_low(pulse_low)
  );

  rpi_flag #(.SEC_PER_MIN(SEC_PER_MIN)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .level_sec(dec.level_sec),
    .level_min(dec.level_min),
    .wr       (flag_wr),
    .wdata    (flag_wdata),
    .flag     (flag)
  );

  // open-drain style: 0 pulls the pin low, 1 releases it
  assign irq_n = ~(pulse_low | ((dec.level_sec | dec.level_min) & flag));

  p_off_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec == '0) |-> irq_n);
  p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && $past(dec.level_sec)) |-> flag);
  p_level_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec.level_min |-> (irq_n == !flag));

endmodule

// File: tb/rtc_periodic_irq_tb.sv
module rtc_periodic_irq_tb;

  localparam int TPS  = 32;
  localparam int WIN  = 20;
  localparam int SPM  = 60;
  localparam int MADJ = 3;
  localparam int AW   = 4;
  localparam int WATCHDOG = 150000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 tick = 1'b0;
  logic [2:0]           period_sel = 3'd0;
  logic                 flag_wr = 1'b0;
  logic                 flag_wdata = 1'b0;
  logic signed [AW-1:0] adj_step = '0;
  logic                 sec_strobe, flag, irq_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rtc_periodic_irq #(
    .TICKS_PER_SEC(TPS), .WINDOW_SEC(WIN), .SEC_PER_MIN(SPM),
    .MAX_ADJ(MADJ), .ADJ_W(AW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_sel(period_sel),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .adj_step(adj_step),
    .sec_strobe(sec_strobe), .flag(flag), .irq_n(irq_n)
  );

  // reference model, built from the requirements
  int m_pos, m_stall, m_win, m_min;
  bit m_flag, m_str, m_lastwr;

  function automatic int clampv(input int a);
    if (a > MADJ) return MADJ;
    if (a < -MADJ) return -MADJ;
    return a;
  endfunction

  function automatic bit exp_irq(input logic [2:0] sel, input int pos, input int stall, input bit f);
    case (sel)
      3'd1: return !((pos % (TPS/2)) < TPS/4);
      3'd2: return !((pos < TPS/2) || (stall > 0));
      3'd3, 3'd4: return !f;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit bnd;
    int a;
    if (!rst_n) begin
      m_pos = 0; m_stall = 0; m_win = 0; m_min = 0;
      m_flag = 0; m_str = 0; m_lastwr = 0;
    end else begin
      bnd = tick && (m_stall == 0) && (m_pos == TPS-1);
      if (bnd && (period_sel == 3'd3 || (period_sel == 3'd4 && m_min == SPM-1))) m_flag = 1;
      else if (flag_wr && !flag_wdata) m_flag = 0;
      m_lastwr = flag_wr;
      if (bnd) m_min = (m_min == SPM-1) ? 0 : m_min + 1;
      m_str = bnd;
      if (tick) begin
        if (m_stall > 0) m_stall--;
        else if (bnd) begin
          m_win = (m_win == WIN-1) ? 0 : m_win + 1;
          m_pos = 0;
          if (m_win == 0) begin
            a = clampv(int'(adj_step));
            if (a > 0) m_stall = a;
            else m_pos = -a;
          end
        end else m_pos++;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    string ti, tf;
    case (period_sel)
      3'd1: ti = "R4 2Hz pin";
      3'd2: ti = (m_stall > 0 || m_win == 0) ? "R9 adjusted 1Hz pin" : "R3 1Hz pin";
      3'd3: ti = "R5 level-sec pin";
      3'd4: ti = "R6 level-min pin";
      default: ti = "R8 off pin";
    endcase
    if (m_lastwr) tf = "R7 flag after write";
    else if (period_sel == 3'd4) tf = "R6 flag";
    else if (period_sel == 3'd3) tf = "R5 flag";
    else tf = "R8 flag";
    check(ti, irq_n, exp_irq(period_sel, m_pos, m_stall, m_flag));
    check(tf, flag, m_flag);
    check("R2 sec_strobe", sec_strobe, m_str);
  endtask

  task automatic run_phase(input logic [2:0] sel, input int ncyc, input int tick_pct, input int wr_pct);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      cyc++;
      compare_all();
      period_sel = sel;
      tick       = (($urandom % 100) < tick_pct);
      flag_wr    = (($urandom % 100) < wr_pct);
      flag_wdata = $urandom % 2;
      adj_step   = AW'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset irq_n", irq_n, 1'b1);
    check("R1 reset flag", flag, 1'b0);
    check("R1 reset sec_strobe", sec_strobe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset irq_n", irq_n, 1'b1);
    check("R1 post-reset flag", flag, 1'b0);
    // pulse modes with random tick density and random adjust steps (R3, R4, R9)
    run_phase(3'd2, 3000, 75, 0);
    run_phase(3'd1, 2500, 60, 0);
    // directed: held positive then negative extreme steps over full windows (R9)
    adj_step = 4'sd7;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < WIN*TPS + 10; i++) begin
        @(negedge clk); cyc++; compare_all();
        period_sel = 3'd2; tick = 1'b1; flag_wr = 1'b0;
        adj_step = (k == 0) ? 4'sd7 : -4'sd8;
      end
    end
    // level modes with random clearing writes of both data values (R5, R6, R7)
    run_phase(3'd3, 3000, 70, 20);
    run_phase(3'd4, SPM*TPS + 200, 100, 0);
    run_phase(3'd4, SPM*TPS + 200, 100, 2);
    // directed: write 1 must leave a set flag alone (R7)
    @(negedge clk); cyc++; compare_all();
    flag_wr = 1'b1; flag_wdata = 1'b1; tick = 1'b0;
    @(negedge clk); cyc++; compare_all();
    check("R7 write of 1 keeps flag", flag, m_flag);
    flag_wr = 1'b0;
    // disabled codes (R8)
    run_phase(3'd5, 800, 80, 5);
    run_phase(3'd7, 400, 80, 5);
    run_phase(3'd0, 800, 80, 5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < WATCHDOG; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule